// File: doc/BRIEF.md
# In-Order Data Bus Sequence Tracker

Each node on a shared bus with separate address and data paths keeps one copy of this tracker. The data path has no arbiter of its own: data transfers must follow the order in which commands were acknowledged on the address path. On every acknowledge, the tracker gives the command the next value of a wrapping 4-bit tag. It also notes whether this node must drive the data for that command. This is the case when the node is the responding target, or when it is the issuer of a broadcast register write.

A completion pointer names the oldest command still outstanding. When that oldest command belongs to this node and local data is ready, the tracker raises its start signal. When the oldest command belongs to someone else, a data-start strobe seen from another node retires it. Three things break the ordering: a start seen from another node while nothing is outstanding, a start from another node in a slot this node owns, and more than sixteen outstanding commands. Each of these is fatal. The tracker pulses an error flag, drops every outstanding entry and returns both its issue and completion counters to zero.

Top module: `dbus_order_tracker`

## Requirements
- R1: After reset, no commands are outstanding, and both `start_xfer` and `seq_err` are low.
- R2: Each cycle with `cmd_ack` high appends one command at the tail, tagged with the next 4-bit issue number, which wraps from 15 to 0. The value of `cmd_mine` in that cycle records whether this node drives its data. Retirement follows acknowledge order across the wrap.
- R3: `start_xfer` is high in a cycle exactly when at least one command is outstanding, the oldest one is marked as this node's, and `data_ready` is high. The output is combinational in that cycle.
- R4: A cycle with `dstart_obs` high, while the oldest outstanding command is not this node's, retires that command at the next clock edge.
- R5: A cycle with `start_xfer` high retires the oldest command at the next clock edge.
- R6: `dstart_obs` high while no command is outstanding is a sequence error.
- R7: `dstart_obs` high while the oldest outstanding command is this node's is a sequence error.
- R8: At most 16 commands may be outstanding. An acknowledge while 16 are outstanding is a sequence error unless a retirement happens in the same cycle, in which case the acknowledge is accepted.
- R9: On a sequence error, all outstanding commands are discarded at that clock edge, and the issue and completion counters both return to zero. A command acknowledged in the offending cycle is discarded as well.
- R10: `seq_err` is a registered one-cycle pulse. It is high in the cycle after each offending cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_ack | input | 1 | A command was acknowledged on the address bus this cycle |
| cmd_mine | input | 1 | With cmd_ack: this node drives the data for that command |
| data_ready | input | 1 | Local data is available for this node's oldest owned transfer |
| dstart_obs | input | 1 | Another node started a data transfer this cycle |
| start_xfer | output | 1 | This node may start its data transfer now |
| seq_err | output | 1 | One-cycle pulse: fatal ordering error, tracker flushed |

## Verification
A queue model in the bench mirrors the ownership flags and is compared against both outputs every cycle. Several traffic patterns are used, and each isolates a different fault:
- Foreign-only traffic shows whether peer starts retire entries in order.
- Owned traffic with `data_ready` held low shows whether the start is gated by readiness.
- A long interleaved run of more than 16 commands with mixed ownership catches tag-wrap and ordering faults.
- Deliberate violations (a stray start, a stolen slot, a 17th acknowledge) separate correct error detection from false alarms.
- Full-queue acknowledges paired with a same-cycle retirement catch an overflow check that is too strict.
- Traffic issued after each flush shows whether stale entries survive.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    localparam int TAG_W = 4;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_STRAY    = 2'd1,
        CAUSE_STEAL    = 2'd2,
        CAUSE_OVERFLOW = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic ack;
        logic peer_start;
        logic own_start;
        logic head_mine;
    } bus_evt_t;

    function automatic logic occ_full(input logic [TAG_W:0] occ, input int depth);
        return occ == (TAG_W + 1)'(depth);
    endfunction

endpackage

// File: rtl/dbt_seq_ctr.sv
module dbt_seq_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst || clr) val <= '0;
        else if (inc)   val <= val + 1'b1;
    end

    assert_ctr_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (val == '0));
endmodule

// File: rtl/dbt_owner_tbl.sv
module dbt_owner_tbl #(
    parameter int W     = 4,
    localparam int DEPTH = 1 << W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_idx,
    input  logic         wr_mine,
    input  logic         ret_en,
    input  logic [W-1:0] ret_idx,
    input  logic [W-1:0] rd_idx,
    output logic         rd_mine
);
    logic [DEPTH-1:0] mine_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                mine_q[g] <= 1'b0;
            end else begin
                if (ret_en && ret_idx == W'(g)) mine_q[g] <= 1'b0;
                if (wr_en && wr_idx == W'(g))   mine_q[g] <= wr_mine;
            end
        end
    end

    assign rd_mine = mine_q[rd_idx];

    assert_slot_written_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> (mine_q[$past(wr_idx)] == $past(wr_mine)));
endmodule

// File: rtl/dbt_seq_check.sv
module dbt_seq_check
    import dbt_pkg::*;
#(
    parameter int W      = 4,
    localparam int DEPTH = 1 << W
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_evt_t     evt,
    output logic         empty,
    output logic         accept,
    output logic         retire,
    output logic         fatal,
    output fault_cause_e cause
);
    logic [W:0] occ_q;
    logic       full;

    assign empty = (occ_q == '0);
    assign full  = (occ_q == (W + 1)'(DEPTH));

    always_comb begin
        cause = CAUSE_NONE;
        if (evt.peer_start && empty)
            cause = CAUSE_STRAY;
        else if (evt.peer_start && evt.head_mine)
            cause = CAUSE_STEAL;
        else if (evt.ack && full && !evt.own_start && !evt.peer_start)
            cause = CAUSE_OVERFLOW;
    end

    assign fatal  = (cause != CAUSE_NONE);
    assign retire = !fatal && !empty && (evt.own_start || (evt.peer_start && !evt.head_mine));
    assign accept = !fatal && evt.ack;

    always_ff @(posedge clk) begin
        if (rst || fatal)            occ_q <= '0;
        else if (accept && !retire)  occ_q <= occ_q + 1'b1;
        else if (retire && !accept)  occ_q <= occ_q - 1'b1;
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        occ_q <= (W + 1)'(DEPTH));
    assert_full_ack_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (full && evt.ack && evt.own_start) |=> (occ_q == (W + 1)'(DEPTH)));
endmodule

// File: rtl/dbus_order_tracker.sv
module dbus_order_tracker
    import dbt_pkg::*;
#(
    parameter int SEQ_W = TAG_W
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_ack,
    input  logic cmd_mine,
    input  logic data_ready,
    input  logic dstart_obs,
    output logic start_xfer,
    output logic seq_err
);
    logic [SEQ_W-1:0] issue_tag;
    logic [SEQ_W-1:0] head_tag;
    logic             head_mine;
    logic             empty, accept, retire, fatal;
    fault_cause_e     cause;
    bus_evt_t         evt;
    logic             err_q;

    assign start_xfer = !empty && head_mine && data_ready;

    assign evt = '{ack: cmd_ack, peer_start: dstart_obs,
                   own_start: start_xfer, head_mine: head_mine && !empty};

    dbt_seq_check #(.W(SEQ_W)) u_check (
        .clk(clk), .rst(rst), .evt(evt), .empty(empty),
        .accept(accept), .retire(retire), .fatal(fatal), .cause(cause)
    );

    dbt_seq_ctr #(.W(SEQ_W)) u_issue (
        .clk(clk), .rst(rst), .clr(fatal), .inc(accept), .val(issue_tag)
    );

    dbt_seq_ctr #(.W(SEQ_W)) u_done (
        .clk(clk), .rst(rst), .clr(fatal), .inc(retire), .val(head_tag)
    );

    dbt_owner_tbl #(.W(SEQ_W)) u_owner (
        .clk(clk), .rst(rst), .flush(fatal),
        .wr_en(accept), .wr_idx(issue_tag), .wr_mine(cmd_mine),
        .ret_en(retire), .ret_idx(head_tag),
        .rd_idx(head_tag), .rd_mine(head_mine)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= fatal;
    end
    assign seq_err = err_q;

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
        start_xfer |-> (data_ready && !empty));
    assert_stray_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (dstart_obs && empty) |=> seq_err);
    assert_flushed_R9: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (empty && issue_tag == '0 && head_tag == '0));
    assert_steal_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (dstart_obs && !empty && head_mine) |=> seq_err);
    assert_stable_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!cmd_ack && !dstart_obs && !start_xfer) |=> $stable(head_tag));
endmodule

// File: tb/sim_dbus_order_tracker.sv
`timescale 1ns/1ps
module sim_dbus_order_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_ack = 1'b0, cmd_mine = 1'b0, data_ready = 1'b0, dstart_obs = 1'b0;
    logic start_xfer, seq_err;

    int   n_run = 0;
    int   n_fail = 0;
    bit   q[$];
    bit   exp_err = 1'b0;

    always #4 clk = ~clk;

    dbus_order_tracker u0 (
        .clk(clk), .rst(rst), .cmd_ack(cmd_ack), .cmd_mine(cmd_mine),
        .data_ready(data_ready), .dstart_obs(dstart_obs),
        .start_xfer(start_xfer), .seq_err(seq_err)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit ack, input bit mine, input bit rdy, input bit peer, input string tag);
        bit exp_start, empty, full, done, err;
        @(negedge clk);
        cmd_ack = ack; cmd_mine = mine; data_ready = rdy; dstart_obs = peer;
        #2;
        empty     = (q.size() == 0);
        full      = (q.size() == 16);
        exp_start = !empty && q[0] && rdy;
        check(tag, start_xfer, exp_start, "start_xfer");
        check("R10", seq_err, exp_err, "seq_err");
        err  = (peer && (empty || q[0])) || (ack && full && !exp_start && !peer);
        done = !err && !empty && (exp_start || peer);
        @(posedge clk);
        if (err) begin
            q.delete();
        end else begin
            if (done) void'(q.pop_front());
            if (ack)  q.push_back(mine);
        end
        exp_err = err;
    endtask

    function automatic bit head_foreign();
        return q.size() > 0 && !q[0];
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", start_xfer, 1'b0, "start_xfer after reset");
        check("R1", seq_err, 1'b0, "seq_err after reset");
        step(0, 0, 1, 0, "R1");

        // R4: foreign-only traffic retired by peer starts
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, 0, 1, head_foreign(), "R4");

        // R3/R5: owned traffic held by data_ready
        step(1, 1, 0, 0, "R3");
        step(1, 1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R5");

        // R2: long interleaved run across tag wrap
        for (int i = 0; i < 60; i++) begin
            bit rdy = (i % 4) != 1;
            bit pr  = head_foreign() && (i % 3 != 0);
            bit ack = (q.size() < 16) && (i % 5 != 4) && (i < 48);
            step(ack, (i % 3) == 0, rdy, pr, "R2");
        end
        for (int i = 0; i < 20; i++) step(0, 0, 1, head_foreign(), "R2");

        // R6: stray peer start with nothing outstanding
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R6");

        // R7: peer steals an owned slot, then flush check (R9)
        step(1, 1, 0, 0, "R7");
        step(1, 0, 0, 0, "R7");
        step(0, 0, 0, 1, "R7");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 1, "R9");
        step(0, 0, 0, 0, "R9");

        // R8: fill to 16, full-ack with retire is accepted, then 17th faults
        for (int i = 0; i < 16; i++) step(1, (i == 0), 0, 0, "R8");
        step(1, 0, 1, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, "R8");
        step(0, 0, 1, 0, "R9");
        step(1, 1, 1, 0, "R9");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, "R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule